// File: doc/BRIEF.md
# Core Register and Stack Unit

This unit holds the architectural registers of an 8051-style processor core: the accumulator, the B register, the program status word, the stack pointer, the 16-bit program counter and two 16-bit data pointers. Software reaches these registers through an 8-bit special-function-register (SFR) port. Writes take effect on the next clock edge, and reads are combinational. The decoder drives push and pop strobes, and the unit returns the internal-RAM address that the stack access must use.

The unit also turns the two bank-select bits of the status word into the internal-RAM address of working register R0..R7. It keeps the parity flag equal to the parity of the accumulator. Instruction decode, the ALU and the RAM arrays sit outside. This unit only supplies their addresses and flags.

Top module: `core_reg_unit`

## Requirements
- R1: While reset is held, the outputs show SP = 0x07, PC = 0x0000, and ACC, B, PSW and both data pointers all zero.
- R2: In a push cycle, stackAddr equals SP+1. From the next cycle SP holds that value, so the first push after reset uses address 0x08.
- R3: In a pop cycle (no push), stackAddr equals SP and SP decrements in the next cycle. SP wraps modulo 256 in both directions (0x00 pop gives 0xFF, 0xFF push gives 0x00).
- R4: An SFR write is visible from the next cycle at addresses ACC 0xE0, B 0xF0, PSW 0xD0 and SP 0x81. Reads of any other address return 0x00, and writes to other addresses change no register.
- R5: The first data pointer sits at 0x82 (low byte) and 0x83 (high byte), and the second at 0x84 (low) and 0x85 (high). Writing one byte leaves the other byte and the other pointer unchanged. dptrOut carries pointer 0 in bits 15:0 and pointer 1 in bits 31:16.
- R6: PSW bits 7..0 are carry, auxiliary carry, F0, RS1, RS0, overflow, user flag and parity. regAddr = RS1:RS0 × 8 + regSel, giving banks 0x00–0x07, 0x08–0x0F, 0x10–0x17 and 0x18–0x1F.
- R7: PSW bit 0 is 1 exactly when ACC holds an odd number of ones. It follows ACC in the same cycle ACC changes, and writes to that bit are ignored.
- R8: An SFR write to SP in the same cycle as a push or pop wins. SP takes the written byte and stackAddr still reports the push/pop address.
- R9: pcInc advances PC by one modulo 65536. pcLoad loads pcLoadVal and has priority over pcInc.
- R10: When push and pop are asserted together, the push is performed and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrAddr | input | 8 | SFR address for read and write |
| sfrWrEn | input | 1 | SFR write strobe |
| sfrWrData | input | 8 | SFR write data |
| sfrRdData | output | 8 | SFR read data (combinational) |
| pushReq | input | 1 | Stack push strobe |
| popReq | input | 1 | Stack pop strobe |
| stackAddr | output | 8 | Internal-RAM address for the current stack access |
| regSel | input | 3 | Working register index R0..R7 |
| regAddr | output | 8 | Internal-RAM address of the selected working register |
| pcInc | input | 1 | Advance program counter |
| pcLoad | input | 1 | Load program counter |
| pcLoadVal | input | 16 | Program counter load value |
| pcOut | output | 16 | Program counter |
| accOut | output | 8 | Accumulator |
| pswOut | output | 8 | Program status word including live parity |
| spOut | output | 8 | Stack pointer |
| dptrOut | output | 32 | Both data pointers, pointer 0 in the low half |

## Verification
The combinational results (stackAddr, regAddr, sfrRdData) are due in the same cycle as the address or strobe that selects them. Register contents (SP, PC, ACC, B, PSW, data pointers) change on the first rising edge after the strobe. Parity follows ACC in that same cycle. The bench drives inputs on the falling edge and compares every output against its reference model shortly afterwards. It advances the model only at the rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/core_reg_pkg.sv
package core_reg_pkg;
  localparam int DATA_W     = 8;
  localparam int PC_W       = 16;
  localparam int NUM_DPTR   = 2;
  localparam int DPTR_IDX_W = (NUM_DPTR > 1) ? $clog2(NUM_DPTR) : 1;
  localparam int REG_IDX_W  = 3;
  localparam int BANK_W     = 2;

  localparam logic [DATA_W-1:0] ADDR_ACC       = 8'hE0;
  localparam logic [DATA_W-1:0] ADDR_B         = 8'hF0;
  localparam logic [DATA_W-1:0] ADDR_PSW       = 8'hD0;
  localparam logic [DATA_W-1:0] ADDR_SP        = 8'h81;
  localparam logic [DATA_W-1:0] ADDR_DPTR_BASE = 8'h82;
  localparam logic [DATA_W-1:0] SP_RESET       = 8'h07;

  // status word bit positions (fixed by instruction semantics)
  localparam int PSW_RS_LO = 3;

  typedef enum logic [2:0] {
    RD_NONE, RD_ACC, RD_B, RD_PSW, RD_SP, RD_DPL, RD_DPH
  } rdSel_e;

  typedef struct packed {
    logic                  wrAcc;
    logic                  wrB;
    logic                  wrPsw;
    logic                  wrSp;
    logic [NUM_DPTR-1:0]   wrDpl;
    logic [NUM_DPTR-1:0]   wrDph;
    logic                  spInc;
    logic                  spDec;
    logic                  pushSel;
    logic                  pcLd;
    logic                  pcAdv;
    rdSel_e                rdSel;
    logic [DPTR_IDX_W-1:0] rdIdx;
  } strobes_t;
endpackage

// File: rtl/core_reg_ctrl.sv
module core_reg_ctrl
  import core_reg_pkg::*;
(
  input  logic [DATA_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              pcInc,
  input  logic              pcLoad,
  output strobes_t          st
);
  always_comb begin
    st       = '0;
    st.rdSel = RD_NONE;
    unique case (sfrAddr)
      ADDR_ACC: st.rdSel = RD_ACC;
      ADDR_B:   st.rdSel = RD_B;
      ADDR_PSW: st.rdSel = RD_PSW;
      ADDR_SP:  st.rdSel = RD_SP;
      default:  st.rdSel = RD_NONE;
    endcase
    for (int i = 0; i < NUM_DPTR; i++) begin
      if (sfrAddr == ADDR_DPTR_BASE + DATA_W'(2 * i)) begin
        st.rdSel = RD_DPL;
        st.rdIdx = DPTR_IDX_W'(i);
        st.wrDpl[i] = sfrWrEn;
      end
      if (sfrAddr == ADDR_DPTR_BASE + DATA_W'(2 * i + 1)) begin
        st.rdSel = RD_DPH;
        st.rdIdx = DPTR_IDX_W'(i);
        st.wrDph[i] = sfrWrEn;
      end
    end
    st.wrAcc   = sfrWrEn && (sfrAddr == ADDR_ACC);
    st.wrB     = sfrWrEn && (sfrAddr == ADDR_B);
    st.wrPsw   = sfrWrEn && (sfrAddr == ADDR_PSW);
    st.wrSp    = sfrWrEn && (sfrAddr == ADDR_SP);
    // software write to SP outranks the core; push outranks pop
    st.pushSel = pushReq;
    st.spInc   = pushReq && !st.wrSp;
    st.spDec   = popReq && !pushReq && !st.wrSp;
    st.pcLd    = pcLoad;
    st.pcAdv   = pcInc && !pcLoad;
  end
endmodule

// File: rtl/core_reg_dp.sv
module core_reg_dp
  import core_reg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 st,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [PC_W-1:0]          pcLoadVal,
  input  logic [REG_IDX_W-1:0]     regSel,
  output logic [DATA_W-1:0]        rdData,
  output logic [DATA_W-1:0]        stackAddr,
  output logic [DATA_W-1:0]        regAddr,
  output logic [DATA_W-1:0]        accOut,
  output logic [DATA_W-1:0]        pswOut,
  output logic [DATA_W-1:0]        spOut,
  output logic [PC_W-1:0]          pcOut,
  output logic [NUM_DPTR*16-1:0]   dptrOut
);
  logic [DATA_W-1:0] accQ, bQ, spQ;
  logic [DATA_W-2:0] pswHiQ;   // bits 7:1, parity is derived
  logic [PC_W-1:0]   pcQ;
  logic [DATA_W-1:0] dplQ [NUM_DPTR];
  logic [DATA_W-1:0] dphQ [NUM_DPTR];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      bQ     <= '0;
      pswHiQ <= '0;
      spQ    <= SP_RESET;
      pcQ    <= '0;
    end else begin
      if (st.wrAcc) accQ   <= wrData;
      if (st.wrB)   bQ     <= wrData;
      if (st.wrPsw) pswHiQ <= wrData[DATA_W-1:1];
      if (st.wrSp)       spQ <= wrData;
      else if (st.spInc) spQ <= spQ + 1'b1;
      else if (st.spDec) spQ <= spQ - 1'b1;
      if (st.pcLd)       pcQ <= pcLoadVal;
      else if (st.pcAdv) pcQ <= pcQ + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_DPTR; g++) begin : gDptr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dplQ[g] <= '0;
        dphQ[g] <= '0;
      end else begin
        if (st.wrDpl[g]) dplQ[g] <= wrData;
        if (st.wrDph[g]) dphQ[g] <= wrData;
      end
    end
    assign dptrOut[g*16 +: 16] = {dphQ[g], dplQ[g]};
  end

  assign accOut    = accQ;
  assign pswOut    = {pswHiQ, ^accQ};
  assign spOut     = spQ;
  assign pcOut     = pcQ;
  assign stackAddr = st.pushSel ? spQ + 1'b1 : spQ;
  assign regAddr   = DATA_W'({pswOut[PSW_RS_LO +: BANK_W], regSel});

  always_comb begin
    unique case (st.rdSel)
      RD_ACC:  rdData = accQ;
      RD_B:    rdData = bQ;
      RD_PSW:  rdData = pswOut;
      RD_SP:   rdData = spQ;
      RD_DPL:  rdData = dplQ[st.rdIdx];
      RD_DPH:  rdData = dphQ[st.rdIdx];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/core_reg_unit.sv
module core_reg_unit
  import core_reg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DATA_W-1:0]      sfrAddr,
  input  logic                   sfrWrEn,
  input  logic [DATA_W-1:0]      sfrWrData,
  output logic [DATA_W-1:0]      sfrRdData,
  input  logic                   pushReq,
  input  logic                   popReq,
  output logic [DATA_W-1:0]      stackAddr,
  input  logic [REG_IDX_W-1:0]   regSel,
  output logic [DATA_W-1:0]      regAddr,
  input  logic                   pcInc,
  input  logic                   pcLoad,
  input  logic [PC_W-1:0]        pcLoadVal,
  output logic [PC_W-1:0]        pcOut,
  output logic [DATA_W-1:0]      accOut,
  output logic [DATA_W-1:0]      pswOut,
  output logic [DATA_W-1:0]      spOut,
  output logic [NUM_DPTR*16-1:0] dptrOut
);
  strobes_t st;

  core_reg_ctrl u_ctrl (
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .pushReq(pushReq),
    .popReq(popReq), .pcInc(pcInc), .pcLoad(pcLoad), .st(st)
  );

  core_reg_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(sfrWrData),
    .pcLoadVal(pcLoadVal), .regSel(regSel), .rdData(sfrRdData),
    .stackAddr(stackAddr), .regAddr(regAddr), .accOut(accOut),
    .pswOut(pswOut), .spOut(spOut), .pcOut(pcOut), .dptrOut(dptrOut)
  );
endmodule

// File: rtl/core_reg_chk.sv
module core_reg_chk
  import core_reg_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [DATA_W-1:0]    sfrAddr,
  input logic                 sfrWrEn,
  input logic [DATA_W-1:0]    sfrWrData,
  input logic                 pushReq,
  input logic                 popReq,
  input logic [DATA_W-1:0]    stackAddr,
  input logic [REG_IDX_W-1:0] regSel,
  input logic [DATA_W-1:0]    regAddr,
  input logic                 pcInc,
  input logic                 pcLoad,
  input logic [PC_W-1:0]      pcLoadVal,
  input logic [PC_W-1:0]      pcOut,
  input logic [DATA_W-1:0]    accOut,
  input logic [DATA_W-1:0]    pswOut,
  input logic [DATA_W-1:0]    spOut
);
  logic spWr;
  assign spWr = sfrWrEn && (sfrAddr == ADDR_SP);

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !spWr) |=> spOut == 8'($past(spOut) + 8'd1));

  assert_push_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |-> stackAddr == 8'(spOut + 8'd1));

  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && !spWr) |=> spOut == 8'($past(spOut) - 8'd1));

  assert_acc_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sfrWrEn && sfrAddr == ADDR_ACC) |=> accOut == $past(sfrWrData));

  assert_bank_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 8'({pswOut[4:3], 3'b000} + {5'b0, regSel}));

  assert_parity_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sfrWrEn && sfrAddr == ADDR_ACC) |=> pswOut[0] == ^$past(sfrWrData));

  assert_sp_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    spWr |=> spOut == $past(sfrWrData));

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pcInc && !pcLoad) |=> pcOut == 16'($past(pcOut) + 16'd1));

  assert_pc_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> pcOut == $past(pcLoadVal));
endmodule

bind core_reg_unit core_reg_chk u_chk (
  .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
  .sfrWrData(sfrWrData), .pushReq(pushReq), .popReq(popReq),
  .stackAddr(stackAddr), .regSel(regSel), .regAddr(regAddr),
  .pcInc(pcInc), .pcLoad(pcLoad), .pcLoadVal(pcLoadVal), .pcOut(pcOut),
  .accOut(accOut), .pswOut(pswOut), .spOut(spOut)
);

// File: tb/sim_core_reg_unit.sv
`timescale 1ns/1ps
module sim_core_reg_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic [7:0]  sfrAddr, sfrWrData, sfrRdData, stackAddr, regAddr;
  logic [7:0]  accOut, pswOut, spOut;
  logic        sfrWrEn, pushReq, popReq, pcInc, pcLoad;
  logic [2:0]  regSel;
  logic [15:0] pcLoadVal, pcOut;
  logic [31:0] dptrOut;

  core_reg_unit u0 (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .pushReq(pushReq),
    .popReq(popReq), .stackAddr(stackAddr), .regSel(regSel),
    .regAddr(regAddr), .pcInc(pcInc), .pcLoad(pcLoad),
    .pcLoadVal(pcLoadVal), .pcOut(pcOut), .accOut(accOut),
    .pswOut(pswOut), .spOut(spOut), .dptrOut(dptrOut)
  );

  // behavioural reference state
  int unsigned mAcc, mB, mPsw, mSp, mPc;
  int unsigned mDpl[2], mDph[2];
  int total = 0, bad = 0;

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned parityOf(int unsigned v);
    return $countones(v & 32'hFF) % 2;
  endfunction

  function automatic int unsigned expPsw();
    return (mPsw & 32'hFE) | parityOf(mAcc);
  endfunction

  function automatic int unsigned expRd(int unsigned a);
    case (a)
      32'hE0: return mAcc;
      32'hF0: return mB;
      32'hD0: return expPsw();
      32'h81: return mSp;
      32'h82: return mDpl[0];
      32'h83: return mDph[0];
      32'h84: return mDpl[1];
      32'h85: return mDph[1];
      default: return 0;
    endcase
  endfunction

  task automatic compareAll();
    int unsigned psw;
    psw = expPsw();
    chk("R2 R3 R8 R10 spOut", spOut, mSp);
    chk("R2 R3 R10 stackAddr", stackAddr, pushReq ? (mSp + 1) % 256 : mSp);
    chk("R4 R5 sfrRdData", sfrRdData, expRd(sfrAddr));
    chk("R4 accOut", accOut, mAcc);
    chk("R6 R7 pswOut", pswOut, psw);
    chk("R6 regAddr", regAddr, ((psw >> 3) & 3) * 8 + regSel);
    chk("R9 pcOut", pcOut, mPc);
    chk("R5 dptrOut", dptrOut,
        (mDph[1] << 24) | (mDpl[1] << 16) | (mDph[0] << 8) | mDpl[0]);
  endtask

  task automatic updateModel();
    int unsigned d;
    d = sfrWrData;
    if (sfrWrEn) begin
      case (sfrAddr)
        8'hE0: mAcc = d;
        8'hF0: mB = d;
        8'hD0: mPsw = d & 32'hFE;
        8'h82: mDpl[0] = d;
        8'h83: mDph[0] = d;
        8'h84: mDpl[1] = d;
        8'h85: mDph[1] = d;
        default: ;
      endcase
    end
    if (sfrWrEn && sfrAddr == 8'h81) mSp = d;
    else if (pushReq) mSp = (mSp + 1) % 256;
    else if (popReq) mSp = (mSp + 255) % 256;
    if (pcLoad) mPc = pcLoadVal;
    else if (pcInc) mPc = (mPc + 1) % 65536;
  endtask

  task automatic step(logic [7:0] a, logic we, logic [7:0] d, logic pu,
                      logic po, logic pi, logic pl, logic [15:0] pv,
                      logic [2:0] rs);
    sfrAddr = a; sfrWrEn = we; sfrWrData = d; pushReq = pu; popReq = po;
    pcInc = pi; pcLoad = pl; pcLoadVal = pv; regSel = rs;
    #1 compareAll();
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    step(a, 1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 3'd0);
  endtask

  task automatic rd(logic [7:0] a, logic [2:0] rs);
    step(a, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, rs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] addrs [10];
    addrs = '{8'hE0, 8'hF0, 8'hD0, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h90, 8'h00};
    rstN = 1'b0;
    sfrAddr = 8'h00; sfrWrEn = 0; sfrWrData = 0; pushReq = 0; popReq = 0;
    pcInc = 0; pcLoad = 0; pcLoadVal = 0; regSel = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset values
    chk("R1 reset sp", spOut, 8'h07);
    chk("R1 reset pc", pcOut, 16'h0000);
    chk("R1 reset acc", accOut, 8'h00);
    chk("R1 reset psw", pswOut, 8'h00);
    chk("R1 reset dptr", dptrOut, 32'h0);
    mAcc = 0; mB = 0; mPsw = 0; mSp = 7; mPc = 0;
    mDpl[0] = 0; mDph[0] = 0; mDpl[1] = 0; mDph[1] = 0;
    @(negedge clk);
    rstN = 1'b1;

    // R2: pushes from reset, first at 0x08
    step(8'h00, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R2 first push lands at 0x08", spOut, 8'h08);
    step(8'h00, 0, 0, 1, 0, 0, 0, 0, 0);
    step(8'h00, 0, 0, 1, 0, 0, 0, 0, 0);
    // R3: pops
    step(8'h00, 0, 0, 0, 1, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 1, 0, 0, 0, 0);
    // R3 wrap downwards and upwards
    wr(8'h81, 8'h00);
    step(8'h00, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3 pop wraps to 0xFF", spOut, 8'hFF);
    step(8'h00, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 push wraps to 0x00", spOut, 8'h00);
    // R8: SFR write beats push and pop
    step(8'h81, 1, 8'h40, 1, 0, 0, 0, 0, 0);
    chk("R8 sp write beats push", spOut, 8'h40);
    step(8'h81, 1, 8'h20, 0, 1, 0, 0, 0, 0);
    chk("R8 sp write beats pop", spOut, 8'h20);
    // R10: push and pop together
    step(8'h00, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R10 push wins over pop", spOut, 8'h21);

    // R4 / R7: accumulator and parity
    wr(8'hE0, 8'h01);
    chk("R7 odd acc sets parity", pswOut[0], 1);
    wr(8'hE0, 8'h03);
    chk("R7 even acc clears parity", pswOut[0], 0);
    wr(8'hD0, 8'hFF);
    chk("R7 parity write ignored", pswOut, 8'hFE);
    wr(8'hF0, 8'h5A);
    rd(8'hF0, 0);
    // R6: bank windows
    rd(8'hD0, 3'd5);
    chk("R6 bank 3 reg 5", regAddr, 8'h1D);
    wr(8'hD0, 8'h08);
    rd(8'hD0, 3'd7);
    chk("R6 bank 1 reg 7", regAddr, 8'h0F);
    wr(8'hD0, 8'h10);
    rd(8'hD0, 3'd0);
    chk("R6 bank 2 reg 0", regAddr, 8'h10);

    // R5: data pointer halves
    wr(8'h82, 8'h34);
    wr(8'h83, 8'h12);
    wr(8'h84, 8'h78);
    wr(8'h85, 8'h56);
    wr(8'h82, 8'hCD);
    chk("R5 dptr halves independent", dptrOut, 32'h567812CD);
    rd(8'h83, 0);
    rd(8'h85, 0);
    // R4 unmapped address
    wr(8'h90, 8'hAA);
    rd(8'h90, 0);
    chk("R4 unmapped reads zero", sfrRdData, 8'h00);

    // R9: program counter
    step(8'h00, 0, 0, 0, 0, 1, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9 pc advanced twice", pcOut, 16'h0002);
    step(8'h00, 0, 0, 0, 0, 0, 1, 16'hFFFF, 0);
    step(8'h00, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9 pc wraps", pcOut, 16'h0000);
    step(8'h00, 0, 0, 0, 0, 1, 1, 16'h1234, 0);
    chk("R9 load beats inc", pcOut, 16'h1234);

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      step(addrs[$urandom_range(0, 9)], 1'($urandom), 8'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0,
           16'($urandom), 3'($urandom));
    end
    rd(8'h00, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule